// File: doc/BRIEF.md
# Six-Digit Display Scanner

This block time-shares a single BCD-to-segment decoder among six seven-segment digits. It keeps six 4-bit digit registers and walks through them one time slot at a time. In each slot it presents one registered 8-bit word made of three fields: a supply/enable bit that is always set, the 3-bit code of the digit being lit, and that digit's BCD value. An external decoder and digit demultiplexer turn this word into segment and digit drive. Every slot lasts the same number of system clocks, set by the `SLOT_CYCLES` parameter. The default of 50,000 clocks at 50 MHz gives a 1 kHz slot rate, which is too fast for a viewer to see any flicker.

Digit values are loaded through a valid/ready write port that carries an index and a value. A transfer takes place on a clock edge where both `wr_valid` and `wr_ready` are high. The port applies back-pressure for one reason only: a write to digit 0 in the cycle where the demo counter advances that digit. The writer must then hold its index and value until `wr_ready` returns, which is always on the next cycle. When `demo_en` is high, digit 0 counts upward on its own. It advances once every `DEMO_FRAMES` complete scans of all six digits.

Top module: `display_scanner`

## Requirements
- R1: A synchronous active-high reset clears all six digit registers to 0, selects digit 0, restarts the slot timer, drives `out_word` to 0x80 and drives `frame_done` low.
- R2: `out_word` bit 7 is always 1, bits 6:4 hold the select code of the digit being shown, and bits 3:0 hold that digit's value. With every digit at zero, the scan emits 128, 144, 160, 176, 192 and 208.
- R3: Select codes run 0,1,2,3,4,5 and then wrap to 0. Each slot lasts exactly `SLOT_CYCLES` clocks. The first slot after reset starts on the first clock edge after reset is released.
- R4: A write accepted on an edge updates the register at `wr_idx`. The new value appears from the first slot of that digit that begins on or after that edge.
- R5: An accepted write whose `wr_idx` is 6 or 7 changes no digit register.
- R6: `frame_done` is high for exactly one clock: the first clock of the slot that follows the digit-5 slot.
- R7: While `demo_en` is high, digit 0 advances by one at the end of every `DEMO_FRAMES`-th complete frame, counted from reset or from the rise of `demo_en`. The value after 9 is 0, and any value above 9 also steps to 0. The new value is shown from the slot-0 that starts at that same edge.
- R8: `wr_ready` is low only when `demo_en` is high, `wr_idx` is 0 and digit 0 advances on the coming edge. In every other cycle it is high.
- R9: `out_word` stays constant for the whole of a slot, even when the digit being shown is written partway through that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_idx | input | 3 | Digit index to write (0 to 5 are valid) |
| wr_value | input | 4 | BCD value to write |
| demo_en | input | 1 | Enables the digit-0 counting demo |
| out_word | output | 8 | {enable, select code, BCD value} for the current slot |
| frame_done | output | 1 | One-clock pulse after each complete six-digit frame |

## Verification
The collision of interest is a host write to digit 0 in the same cycle as a demo advance of that digit. The bench provokes it by raising a write of 7 to digit 0 in the last clock of the fifth demo frame. It then expects `wr_ready` to read low in that cycle and high in the next. It also expects the next frame to show the demo value 1, because the held write lands one cycle after that frame's slot 0 has already latched. From the frame after that on, it expects 7, and it expects the next advance to move 7 to 8.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int SEL_W      = 3;
  localparam int BCD_W      = 4;
  localparam int WORD_W     = 1 + SEL_W + BCD_W;
  localparam logic [BCD_W-1:0] BCD_TOP = 4'd9;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [BCD_W-1:0]  bcd_t;

  function automatic word_t pack_word(sel_t sel, bcd_t val);
    return {1'b1, sel, val};
  endfunction

  function automatic bcd_t bcd_bump(bcd_t val);
    return (val >= BCD_TOP) ? '0 : val + 1'b1;
  endfunction
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
  parameter int SLOT_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_tick_restart_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import disp_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output sel_t sel,
  output sel_t sel_nxt,
  output logic frame_end,
  output logic frame_done
);
  localparam sel_t LAST_SEL = SEL_W'(NUM_DIGITS - 1);

  assign frame_end = tick && (sel == LAST_SEL);

  always_comb begin
    sel_nxt = sel;
    if (tick) sel_nxt = (sel == LAST_SEL) ? '0 : sel + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= '0;
      frame_done <= 1'b0;
    end else begin
      sel        <= sel_nxt;
      frame_done <= frame_end;
    end
  end

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (rst)
    sel <= LAST_SEL);
  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sel));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_done_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (sel == '0));
endmodule

// File: rtl/demo_counter.sv
module demo_counter #(
  parameter int DEMO_FRAMES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic demo_en,
  input  logic frame_end,
  output logic step
);
  localparam int FC_W = (DEMO_FRAMES > 1) ? $clog2(DEMO_FRAMES) : 1;
  localparam logic [FC_W-1:0] LAST = FC_W'(DEMO_FRAMES - 1);

  logic [FC_W-1:0] fcnt;

  assign step = demo_en && frame_end && (fcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !demo_en) fcnt <= '0;
    else if (frame_end)  fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
  end

  assert_frames_range_R7: assert property (@(posedge clk) disable iff (rst)
    fcnt <= LAST);
  assert_frames_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (demo_en && !frame_end) |=> $stable(fcnt));
endmodule

// File: rtl/digit_bank.sv
module digit_bank
  import disp_scan_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  sel_t                            wr_idx,
  input  bcd_t                            wr_value,
  input  logic                            inc0,
  output logic [NUM_DIGITS-1:0][BCD_W-1:0] cur,
  output logic [NUM_DIGITS-1:0][BCD_W-1:0] nxt
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic hit;
    assign hit = wr_en && (wr_idx == SEL_W'(i));

    if (i == 0) begin : g_counting
      always_comb begin
        if (hit)       nxt[i] = wr_value;
        else if (inc0) nxt[i] = bcd_bump(cur[i]);
        else           nxt[i] = cur[i];
      end
    end else begin : g_plain
      always_comb nxt[i] = hit ? wr_value : cur[i];
    end

    always_ff @(posedge clk) begin
      if (rst) cur[i] <= '0;
      else     cur[i] <= nxt[i];
    end
  end

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !inc0) |=> $stable(cur));
endmodule

// File: rtl/display_scanner.sv
module display_scanner
  import disp_scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 50000,
  parameter int DEMO_FRAMES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_idx,
  input  logic [3:0] wr_value,
  input  logic       demo_en,
  output logic [7:0] out_word,
  output logic       frame_done
);
  logic slot_tick, frame_end, demo_step, wr_en;
  sel_t sel, sel_nxt;
  bcd_t shown;
  logic [NUM_DIGITS-1:0][BCD_W-1:0] dig_cur, dig_nxt;

  scan_prescaler #(.SLOT_CYCLES(SLOT_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .tick(slot_tick)
  );

  scan_sequencer u_seq (
    .clk(clk), .rst(rst), .tick(slot_tick), .sel(sel), .sel_nxt(sel_nxt),
    .frame_end(frame_end), .frame_done(frame_done)
  );

  demo_counter #(.DEMO_FRAMES(DEMO_FRAMES)) u_demo (
    .clk(clk), .rst(rst), .demo_en(demo_en), .frame_end(frame_end),
    .step(demo_step)
  );

  // Back-pressure only when the write would collide with a demo advance.
  assign wr_ready = !(demo_step && (wr_idx == '0));
  assign wr_en    = wr_valid && wr_ready && (wr_idx < SEL_W'(NUM_DIGITS));

  digit_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .inc0(demo_step), .cur(dig_cur), .nxt(dig_nxt)
  );

  // Value of the digit that the next slot will show, including same-edge updates.
  always_comb begin
    shown = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (sel_nxt == SEL_W'(i)) shown = dig_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (rst)            out_word <= pack_word('0, '0);
    else if (slot_tick) out_word <= pack_word(sel_nxt, shown);
  end

  assert_word_enable_R2: assert property (@(posedge clk) disable iff (rst)
    out_word[WORD_W-1]);
  assert_word_select_R2: assert property (@(posedge clk) disable iff (rst)
    out_word[WORD_W-2 -: SEL_W] == sel);
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> $stable(out_word));
  assert_ready_cause_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |-> (demo_en && (wr_idx == '0)));
  assert_high_index_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_idx >= SEL_W'(NUM_DIGITS)) && !demo_step) |=> $stable(dig_cur));
endmodule

// File: tb/sim_display_scanner.sv
module sim_display_scanner;
  localparam int S  = 4;
  localparam int DF = 5;
  localparam int FR = 6 * S;

  logic clk = 1'b0, rst = 1'b1, wr_valid = 1'b0, demo_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [3:0] wr_value = '0;
  logic wr_ready, frame_done;
  logic [7:0] out_word;

  int checks = 0, failures = 0, n = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  display_scanner #(.SLOT_CYCLES(S), .DEMO_FRAMES(DF)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_value(wr_value), .demo_en(demo_en),
    .out_word(out_word), .frame_done(frame_done)
  );

  function automatic int wexp(int s, int v);
    return 128 + s * 16 + v;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, n);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic do_reset(bit demo);
    @(negedge clk);
    rst = 1'b1; demo_en = demo; wr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic write_digit(int idx, int val);
    wr_idx = 3'(idx); wr_value = 4'(val); wr_valid = 1'b1;
    #1 chk(wr_ready == 1'b1, "R8 ready without demo", int'(wr_ready), 1);
    step();
    wr_valid = 1'b0;
  endtask

  task automatic check_frame(input int d[6], string req);
    while (n % FR != 0) step();
    for (int s = 0; s < 6; s++) begin
      while (n % FR != s * S + S / 2) step();
      chk(out_word == 8'(wexp(s, d[s])), req, int'(out_word), wexp(s, d[s]));
    end
  endtask

  task automatic t_reset();
    int z[6] = '{0, 0, 0, 0, 0, 0};
    do_reset(1'b0);
    chk(out_word == 8'h80, "R1 reset word", int'(out_word), 128);
    chk(frame_done == 1'b0, "R1 reset frame_done", int'(frame_done), 0);
    check_frame(z, "R1 digits cleared");
  endtask

  task automatic t_scan();
    do_reset(1'b0);
    for (int k = 0; k < 2 * FR + 1; k++) begin
      chk(out_word == 8'(wexp((n / S) % 6, 0)), "R3 R2 slot word", int'(out_word), wexp((n / S) % 6, 0));
      chk(frame_done == (n % FR == 0 && n > 0), "R6 frame_done", int'(frame_done), int'(n % FR == 0 && n > 0));
      step();
    end
  endtask

  task automatic t_writes();
    int d[6] = '{3, 1, 4, 1, 5, 9};
    do_reset(1'b0);
    step();
    for (int i = 0; i < 6; i++) write_digit(i, d[i]);
    check_frame(d, "R4 written digits");
    // Indices above 5 must leave every digit untouched
    write_digit(6, 7);
    write_digit(7, 8);
    check_frame(d, "R5 high index ignored");
    // Mid-slot write to the digit being shown
    while (n % FR != 2 * S + 1) step();
    write_digit(2, 6);
    while (n % FR < 3 * S) begin
      chk(out_word == 8'(wexp(2, 4)), "R9 slot word held", int'(out_word), wexp(2, 4));
      step();
    end
    d[2] = 6;
    check_frame(d, "R4 next slot shows write");
  endtask

  task automatic t_demo_collide();
    int e;
    do_reset(1'b1);
    for (int k = 0; k < 15 * FR; k++) begin
      if (n == 5 * FR - 1) begin
        wr_idx = 3'd0; wr_value = 4'd7; wr_valid = 1'b1;
        #1 chk(wr_ready == 1'b0, "R8 ready low on collision", int'(wr_ready), 0);
      end else if (n == 5 * FR) begin
        #1 chk(wr_ready == 1'b1, "R8 ready back high", int'(wr_ready), 1);
      end else if (n == 5 * FR + 1) begin
        wr_valid = 1'b0;
      end
      if (n % FR == S / 2) begin
        e = (n / FR < 5) ? 0 : (n / FR == 5) ? 1 : (n / FR < 10) ? 7 : 8;
        chk(out_word == 8'(wexp(0, e)), "R7 R8 demo digit", int'(out_word), wexp(0, e));
      end
      step();
    end
  endtask

  task automatic t_demo_wrap();
    int e;
    do_reset(1'b1);
    for (int k = 0; k < 56 * FR; k++) begin
      if (n % FR == S / 2) begin
        e = (n / FR / DF) % 10;
        chk(out_word == 8'(wexp(0, e)), "R7 demo count", int'(out_word), wexp(0, e));
      end
      if (n % FR == 3 * S + S / 2)
        chk(out_word == 8'(wexp(3, 0)), "R7 other digits idle", int'(out_word), wexp(3, 0));
      step();
    end
    // Reset in the middle of a scan with digit 0 non-zero
    while (n % FR != 2 * S + 1) step();
    do_reset(1'b0);
    chk(out_word == 8'h80, "R1 reset mid-scan", int'(out_word), 128);
  endtask

  initial begin
    t_reset();
    t_scan();
    t_writes();
    t_demo_collide();
    t_demo_wrap();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule